// File: doc/BRIEF.md
# Supervisor External Interrupt Pending Bit Logic

This block holds the machine-level state behind bit 9 of the interrupt-pending CSR, which is the supervisor external interrupt pending bit. A software-writable storage bit sits behind that position. The bit the CSR shows is the OR of that storage bit and the live line from the external interrupt controller. The block runs CSR write, set and clear operations against either the pending CSR or the virtual-pending CSR. It returns the combinational read value and drives the effective pending level that the interrupt logic sees.

A mode input takes the place of bit 9 of the virtual-interrupt-enable CSR and picks between two arrangements:
- **Mode low.** The virtual-pending bit aliases the hidden software bit. A read of the virtual-pending CSR shows the stored bit directly. Writes through either CSR land in the same flop.
- **Mode high.** The virtual-pending bit is a separate flop that has no effect on the pending level. Bit 9 of the pending CSR then shows the controller line alone.

Top module: `seip_csr`

## Requirements
- R1: While `rst_ni` is low, both stored bits are 0. Reset is asynchronous and active low, so right after reset every read returns 0 and `seip_o` equals `ext_irq_i`.
- R2: With the mode low (`sep_en_i`=0) and `sel_i`=0 (pending CSR), `rdata_o[9]` is the OR of the hidden software bit and `ext_irq_i`. It reads 1 whenever `ext_irq_i` is high, even when the stored bit is 0.
- R3: With the mode low, `seip_o` is the OR of the hidden software bit and `ext_irq_i`. With the mode high, `seip_o` equals `ext_irq_i` alone, and neither stored bit affects it.
- R4: Write, set and clear compute the new value from the stored bit and `wdata_i[9]` only. The level of `ext_irq_i` never reaches the stored value.
- R5: With the mode low, `sel_i`=1 (virtual-pending CSR) reads the hidden software bit itself in `rdata_o[9]`. An operation through either `sel_i` value updates that same bit.
- R6: With the mode high, `sel_i`=1 reads and updates a separate bit and leaves the hidden software bit alone. Operations with `sel_i`=0 change no stored bit, and that read returns `ext_irq_i` in bit 9. The hidden bit keeps its value across mode changes.
- R7: `op_i` encoding: 2'b00 no change, 2'b01 write, 2'b10 set (OR in the operand), 2'b11 clear (AND with the inverted operand). Set and clear with `wdata_i[9]`=0 leave the stored bits unchanged.
- R8: An operation with `req_i`=1 changes the stored bit at the next rising clock edge. Reads are combinational and show the value before that edge. With `req_i`=0, nothing is stored.
- R9: Every bit of `rdata_o` except bit 9 reads 0, whatever `wdata_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | CSR operation valid this cycle |
| op_i | input | 2 | 00 none, 01 write, 10 set, 11 clear |
| sel_i | input | 1 | 0 pending CSR, 1 virtual-pending CSR |
| wdata_i | input | XLEN | Operand; only bit 9 is used |
| ext_irq_i | input | 1 | Line from the external interrupt controller |
| sep_en_i | input | 1 | Mode: 1 makes the virtual-pending bit separate |
| rdata_o | output | XLEN | Combinational read data for the selected CSR |
| seip_o | output | 1 | Effective supervisor external pending level |

## Verification
Two things can land in the same cycle: a read-modify-write of the hidden bit, and a high controller line that changes what the pending CSR shows. The bench issues set and clear operations with a zero or one operand while `ext_irq_i` is high. It then reads the virtual-pending CSR in the next cycle to confirm that the line did not leak into the stored bit. A long random mix also changes the mode, the target CSR and the controller line on the same cycles as operations. A behavioural model is compared against the read data and the pending level on every cycle.

// File: rtl/seip_pkg.sv
`timescale 1ns/1ps
package seip_pkg;
  typedef enum logic [1:0] {
    CSR_NONE = 2'b00,
    CSR_WR   = 2'b01,
    CSR_SET  = 2'b10,
    CSR_CLR  = 2'b11
  } csr_op_e;

  typedef enum logic {
    SEL_MIP  = 1'b0,
    SEL_MVIP = 1'b1
  } csr_sel_e;

  localparam int unsigned NUM_STORE = 2;
  localparam int unsigned IDX_SW    = 0;
  localparam int unsigned IDX_SEP   = 1;
endpackage

// File: rtl/seip_bit_alu.sv
`timescale 1ns/1ps
module seip_bit_alu
  import seip_pkg::*;
(
  input  csr_op_e op_i,
  input  logic    old_i,
  input  logic    opnd_i,
  output logic    new_o
);
  always_comb begin
    unique case (op_i)
      CSR_WR:  new_o = opnd_i;
      CSR_SET: new_o = old_i | opnd_i;
      CSR_CLR: new_o = old_i & ~opnd_i;
      default: new_o = old_i;
    endcase
  end
endmodule

// File: rtl/seip_store.sv
`timescale 1ns/1ps
module seip_store #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[k] <= 1'b0;
      else if (en_i[k]) q_o[k] <= d_i[k];
    end
  end
endmodule

// File: rtl/seip_rd_mux.sv
`timescale 1ns/1ps
module seip_rd_mux
  import seip_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SEIP_BIT = 9
) (
  input  csr_sel_e        sel_i,
  input  logic            sep_en_i,
  input  logic            sw_i,
  input  logic            sep_i,
  input  logic            ext_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            pend_o
);
  logic rd_bit;

  // separate mode: software bit no longer reaches the pending level
  assign pend_o = sep_en_i ? ext_i : (sw_i | ext_i);

  always_comb begin
    if (sel_i == SEL_MIP) rd_bit = pend_o;
    else                  rd_bit = sep_en_i ? sep_i : sw_i;
    rdata_o           = '0;
    rdata_o[SEIP_BIT] = rd_bit;
  end
endmodule

// File: rtl/seip_csr.sv
`timescale 1ns/1ps
module seip_csr
  import seip_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SEIP_BIT = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      op_i,
  input  logic            sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            ext_irq_i,
  input  logic            sep_en_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            seip_o
);
  localparam int unsigned NS = NUM_STORE;

  csr_op_e  op;
  csr_sel_e sel;
  logic [NS-1:0] st_q, st_en, st_d;
  logic sw_q, sep_q;
  logic tgt_sep, tgt_ign, tgt_old, tgt_new, wr_act;
  logic unused_wdata;

  assign op  = csr_op_e'(op_i);
  assign sel = csr_sel_e'(sel_i);
  assign sw_q  = st_q[IDX_SW];
  assign sep_q = st_q[IDX_SEP];
  assign unused_wdata = ^{wdata_i[XLEN-1:SEIP_BIT+1], wdata_i[SEIP_BIT-1:0]};

  // mip bit 9 is read-only while the virtual bit is separate
  assign tgt_sep = sep_en_i & (sel == SEL_MVIP);
  assign tgt_ign = sep_en_i & (sel == SEL_MIP);
  assign tgt_old = tgt_sep ? sep_q : sw_q;
  assign wr_act  = req_i & (op != CSR_NONE) & ~tgt_ign;

  seip_bit_alu u_alu (
    .op_i   (op),
    .old_i  (tgt_old),
    .opnd_i (wdata_i[SEIP_BIT]),
    .new_o  (tgt_new)
  );

  always_comb begin
    st_en          = '0;
    st_en[IDX_SW]  = wr_act & ~tgt_sep;
    st_en[IDX_SEP] = wr_act & tgt_sep;
    st_d           = {NS{tgt_new}};
  end

  seip_store #(.N(NS)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_en),
    .d_i    (st_d),
    .q_o    (st_q)
  );

  seip_rd_mux #(.XLEN(XLEN), .SEIP_BIT(SEIP_BIT)) u_rd (
    .sel_i    (sel),
    .sep_en_i (sep_en_i),
    .sw_i     (sw_q),
    .sep_i    (sep_q),
    .ext_i    (ext_irq_i),
    .rdata_o  (rdata_o),
    .pend_o   (seip_o)
  );
endmodule

// File: rtl/seip_csr_chk.sv
`timescale 1ns/1ps
module seip_csr_chk #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SEIP_BIT = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [1:0]      op_i,
  input logic            sel_i,
  input logic            wd_bit_i,
  input logic            ext_irq_i,
  input logic            sep_en_i,
  input logic [XLEN-1:0] rdata_o,
  input logic            seip_o,
  input logic            sw_q,
  input logic            sep_q
);
  localparam logic [XLEN-1:0] KEEP = XLEN'(1) << SEIP_BIT;

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~KEEP) == '0);
  // R3
  pend_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sep_en_i |-> seip_o == ext_irq_i);
  // R3
  pend_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sep_en_i |-> seip_o == (sw_q | ext_irq_i));
  // R2
  mip_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sep_en_i && !sel_i) |-> rdata_o[SEIP_BIT] == (sw_q | ext_irq_i));
  // R5
  alias_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sep_en_i && sel_i) |-> rdata_o[SEIP_BIT] == sw_q);
  // R4
  wr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sep_en_i && op_i == 2'b01) |=> sw_q == $past(wd_bit_i));
  // R4
  set_no_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sep_en_i && op_i == 2'b10 && !wd_bit_i && !sw_q) |=> !sw_q);
  // R7
  zero_opnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i[1] && !wd_bit_i) |=> ($stable(sw_q) && $stable(sep_q)));
  // R6
  mip_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sep_en_i && !sel_i) |=> ($stable(sw_q) && $stable(sep_q)));
  // R6
  sep_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sep_en_i) |=> $stable(sw_q));
  // R8
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(sw_q) && $stable(sep_q)));
endmodule

bind seip_csr seip_csr_chk #(.XLEN(XLEN), .SEIP_BIT(SEIP_BIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .op_i      (op_i),
  .sel_i     (sel_i),
  .wd_bit_i  (wdata_i[SEIP_BIT]),
  .ext_irq_i (ext_irq_i),
  .sep_en_i  (sep_en_i),
  .rdata_o   (rdata_o),
  .seip_o    (seip_o),
  .sw_q      (sw_q),
  .sep_q     (sep_q)
);

// File: tb/seip_csr_bench.sv
`timescale 1ns/1ps
module seip_csr_bench;
  localparam int XLEN = 64;
  localparam int SB   = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            req = 1'b0;
  logic [1:0]      op = 2'b00;
  logic            sel = 1'b0;
  logic [XLEN-1:0] wdata = '0;
  logic            ext = 1'b0;
  logic            mode = 1'b0;
  logic [XLEN-1:0] rdata;
  logic            seip;

  int checks = 0;
  int errors = 0;
  bit ms = 1'b0;  // model hidden bit
  bit mv = 1'b0;  // model separate bit

  seip_csr u_seip_csr (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .op_i (op), .sel_i (sel),
    .wdata_i (wdata), .ext_irq_i (ext), .sep_en_i (mode),
    .rdata_o (rdata), .seip_o (seip)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit apply(bit old, logic [1:0] o, bit wb);
    case (o)
      2'b01:   return wb;
      2'b10:   return old | wb;
      2'b11:   return old & ~wb;
      default: return old;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_rd();
    logic [XLEN-1:0] v = '0;
    if (!sel) v[SB] = mode ? ext : (ms | ext);
    else      v[SB] = mode ? mv : ms;
    return v;
  endfunction

  task automatic step(bit r, logic [1:0] o, bit s, bit wb, bit e, bit m, string tag);
    @(negedge clk);
    req = r; op = o; sel = s; ext = e; mode = m;
    wdata = {$urandom, $urandom};
    wdata[SB] = wb;
    #1;
    chk(tag, rdata, exp_rd());
    chk("R3 pending level", {63'b0, seip}, {63'b0, (m ? e : (ms | e))});
    if (r) begin
      if (m && s) mv = apply(mv, o, wb);
      else if (!m) ms = apply(ms, o, wb);
    end
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    sel = 1'b0; #1; chk("R1 reset mip", rdata, '0);
    sel = 1'b1; #1; chk("R1 reset mvip", rdata, '0);
    chk("R1 reset level", {63'b0, seip}, '0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 2'b00, 0, 0, 1, 0, "R2 line alone shows in mip");
    step(0, 2'b00, 1, 0, 1, 0, "R5 line hidden from mvip");
    step(1, 2'b10, 0, 0, 1, 0, "R4 set zero operand with line high");
    step(0, 2'b00, 1, 0, 1, 0, "R4 stored bit free of line");
    step(1, 2'b11, 0, 1, 1, 0, "R4 clear with line high");
    step(1, 2'b01, 0, 1, 0, 0, "R7 write through mip");
    step(0, 2'b00, 1, 0, 0, 0, "R8 write seen next cycle via alias");
    step(1, 2'b10, 1, 0, 0, 0, "R7 set zero operand");
    step(1, 2'b11, 1, 1, 0, 0, "R8 clear via mvip shows old value");
    step(0, 2'b00, 0, 0, 0, 0, "R5 clear via mvip reaches mip");
    step(1, 2'b01, 1, 1, 0, 0, "R5 write via mvip");
    step(0, 2'b00, 0, 0, 0, 1, "R6 mip shows line alone");
    step(1, 2'b01, 1, 1, 0, 1, "R6 write separate bit");
    step(1, 2'b11, 0, 1, 1, 1, "R6 mip write ignored");
    step(0, 2'b00, 1, 0, 0, 1, "R6 separate bit holds");
    step(0, 2'b00, 0, 0, 0, 0, "R6 hidden bit kept across modes");
    step(1, 2'b00, 0, 0, 0, 0, "R7 op none");
    step(0, 2'b00, 1, 0, 1, 0, "R7 op none left bit set");
    step(0, 2'b00, 0, 0, 0, 0, "R9 upper bits zero");

    for (int i = 0; i < 3000; i++) begin
      step(bit'($urandom % 2), 2'($urandom), bit'($urandom % 2), bit'($urandom % 2),
           bit'($urandom % 2), bit'(($urandom % 4) == 0), "R2 R5 R6 R7 random mix");
    end

    @(negedge clk);
    req = 1'b0; mode = 1'b0; ext = 1'b0; sel = 1'b1;
    rst_n = 1'b0; #1;
    ms = 1'b0; mv = 1'b0;
    chk("R1 async reset mid-run", rdata, '0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 2'b00, 1, 0, 0, 1, "R1 separate bit cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule